// File: doc/BRIEF.md
# Cascaded Power-Good Output Sequencer

This block drives four active-low power-good outputs for a hot-swap supply controller. Each output stands for the output enable of an open-drain pad with no pull-up. A bit of `pg_drive_o` at 1 means the pad pulls low, which is the asserted state. A bit at 0 means the pad floats at high impedance. Two digital qualifiers arrive from the analog front end: the pass-gate voltage has reached its level, and the drain sense is below its threshold. While both are true, the first output pulls low in the same cycle.

Each later output joins the chain a fixed `PGD_CYCLES` clocks after the output before it. It does so only while every enable at or above its own level is high. Three active-high enable levels form a hierarchy: level A masks outputs two to four, level B masks three and four, and level C masks four only. An unconnected enable is taken as already high. A low enable releases the outputs it masks at once. No reverse sequence runs. When the enable returns, the affected stage starts a full delay again. The enables pass through a two-flop synchronizer. The qualifiers act without any register.

Top module: `pg_sequencer`

## Requirements
- R1: While `rst_ni` is low, and for two clock edges after it rises, outputs two to four (bits 3:1 of `pg_drive_o`) stay at 0 (released).
- R2: Bit 0 of `pg_drive_o` equals `gate_ok_i & drain_low_i` in the same cycle, with no clock edge in between.
- R3: With all enables high, bit k (k = 1..3) goes to 1 exactly `PGD_CYCLES` rising clock edges after bit k-1 went to 1. A later bit is never 1 while an earlier bit is 0.
- R4: `en_i[0]` (level A) low releases bits 3:1 together and leaves bit 0 unchanged.
- R5: `en_i[1]` (level B) low releases bits 3:2 and does not affect bits 1:0.
- R6: `en_i[2]` (level C) low releases bit 3 only.
- R7: When either qualifier is false, all four bits are 0 in that same cycle, and every stage delay is cleared. After the qualifiers return, the whole sequence runs again from the start.
- R8: When an enable returns high while the predecessor bit is still 1, the re-enabled bit waits the full `PGD_CYCLES` again.
- R9: A change on `en_i` reaches the outputs after exactly two rising clock edges and no more.
- R10: Bit k-1 of `pg_drive_o` is output k of the chain (bit 0 = first). A value of 1 means the pad pulls low.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gate_ok_i | input | 1 | Pass-gate voltage has reached its target level |
| drain_low_i | input | 1 | Drain sense is below its threshold |
| en_i | input | NUM_PG-1 | Enable levels: bit 0 = A, bit 1 = B, bit 2 = C; asynchronous |
| pg_drive_o | output | NUM_PG | Drive-low strobes; bit k-1 = output k; 1 = pull low |

## Verification
Two events can fall in the same clock cycle:
- a stage's delay running out, so its output would assert on the next edge;
- a synchronized enable falling, or a qualifier dropping, which must release that output instead.

The random phase holds the qualifiers high most of the time and drops enable levels with a small probability each cycle. Over a few thousand cycles this lands many enable drops and qualifier drops on the exact edge where a delay expires. Every cycle, the bench compares all four bits with its own cycle model, which counts consecutive qualified cycles per stage. A stage that asserts in a cycle where its mask or qualifier is already low is reported as a failure.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  // Highest number of enable levels the chain helper can examine.
  localparam int unsigned MAX_LEVELS = 8;

  // A stage k is open when enable levels 0..k-1 are all high.
  function automatic logic chain_open(input logic [MAX_LEVELS-1:0] levels,
                                      input int unsigned stage);
    logic open_v;
    open_v = 1'b1;
    for (int i = 0; i < int'(MAX_LEVELS); i++) begin
      if (i < int'(stage) && !levels[i]) open_v = 1'b0;
    end
    return open_v;
  endfunction

  // Down-counter load value: the output asserts on the edge where the counter
  // has already reached zero, so a load of delay-1 gives exactly delay edges.
  function automatic int unsigned delay_load(input int unsigned delay);
    return (delay > 0) ? delay - 1 : 0;
  endfunction

endpackage

// File: rtl/pgseq_sync.sv
module pgseq_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe[s] <= '0;
      end else if (s == 0) begin
        pipe[s] <= async_in;
      end else begin
        pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/pgseq_stage.sv
module pgseq_stage #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qual,      // both qualifiers true
  input  logic pred_on,   // preceding output asserted
  input  logic chain_ok,  // all governing enables high (synchronized)
  output logic armed,     // delay has elapsed under continuous go
  output logic drive      // pull pad low
);

  localparam int unsigned CNT_W = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(pgseq_pkg::delay_load(DELAY));

  logic [CNT_W-1:0] remain;
  logic             go;

  assign go = qual & pred_on & chain_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain <= LOAD;
      armed  <= 1'b0;
    end else if (!go) begin
      remain <= LOAD;
      armed  <= 1'b0;
    end else if (remain == '0) begin
      armed  <= 1'b1;
    end else begin
      remain <= remain - 1'b1;
    end
  end

  // Release is combinational on the current go term: no extra cycle.
  assign drive = armed & go;

endmodule

// File: rtl/pg_sequencer.sv
module pg_sequencer #(
  parameter int unsigned NUM_PG      = 4,
  parameter int unsigned PGD_CYCLES  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gate_ok_i,
  input  logic              drain_low_i,
  input  logic [NUM_PG-2:0] en_i,
  output logic [NUM_PG-1:0] pg_drive_o
);

  localparam int unsigned NUM_EN = NUM_PG - 1;

  // Named internal events, visible to the bound checker.
  logic                              qual;
  logic [NUM_EN-1:0]                 en_sync;
  logic [pgseq_pkg::MAX_LEVELS-1:0]  en_wide;
  logic [NUM_PG-1:0]                 chain_open_w;
  logic [NUM_PG-1:0]                 stage_armed;

  assign qual = gate_ok_i & drain_low_i;

  pgseq_sync #(.WIDTH(NUM_EN), .STAGES(SYNC_STAGES)) u_en_sync (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .async_in (en_i),
    .sync_out (en_sync)
  );

  always_comb begin
    en_wide = '0;
    en_wide[NUM_EN-1:0] = en_sync;
  end

  // First output: immediate on qualifiers.
  assign pg_drive_o[0]   = qual;
  assign stage_armed[0]  = qual;
  assign chain_open_w[0] = 1'b1;

  for (genvar k = 1; k < NUM_PG; k++) begin : g_stage
    assign chain_open_w[k] = pgseq_pkg::chain_open(en_wide, k);

    pgseq_stage #(.DELAY(PGD_CYCLES)) u_stage (
      .clk      (clk_i),
      .rst_n    (rst_ni),
      .qual     (qual),
      .pred_on  (pg_drive_o[k-1]),
      .chain_ok (chain_open_w[k]),
      .armed    (stage_armed[k]),
      .drive    (pg_drive_o[k])
    );
  end

endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker #(
  parameter int unsigned NUM_PG = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gate_ok,
  input logic              drain_low,
  input logic [NUM_PG-2:0] en_sync,
  input logic [NUM_PG-1:0] stage_armed,
  input logic [NUM_PG-1:0] pg_drive
);

  AST_FIRST_TRACKS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    pg_drive[0] == (gate_ok && drain_low)); // R2

  AST_QUAL_CLEARS_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ok && drain_low) |=> (stage_armed[NUM_PG-1:1] == '0)); // R7

  AST_QUAL_RELEASES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_ok && drain_low) |-> (pg_drive == '0)); // R7

  for (genvar k = 1; k < NUM_PG; k++) begin : g_chk
    AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      pg_drive[k] |-> pg_drive[k-1]); // R3

    AST_RISE_AFTER_PRED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_drive[k]) |-> $past(pg_drive[k-1])); // R3

    AST_LEVEL_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      !(&en_sync[k-1:0]) |-> !pg_drive[k]); // R4
  end

endmodule

bind pg_sequencer pgseq_checker #(.NUM_PG(NUM_PG)) u_pgseq_checker (
  .clk         (clk_i),
  .rst_n       (rst_ni),
  .gate_ok     (gate_ok_i),
  .drain_low   (drain_low_i),
  .en_sync     (en_sync),
  .stage_armed (stage_armed),
  .pg_drive    (pg_drive_o)
);

// File: tb/pg_sequencer_bench.sv
`timescale 1ns/1ps
module pg_sequencer_bench;

  localparam int NPG = 4;
  localparam int PGD = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           gate_ok = 1'b0;
  logic           drain_low = 1'b0;
  logic [NPG-2:0] en = '1;
  logic [NPG-1:0] pg;

  int n_checks = 0;
  int n_fail   = 0;

  // Bench model state: synchronizer image and per-stage run lengths.
  logic [NPG-2:0] m_s1 = '0;
  logic [NPG-2:0] m_s2 = '0;
  int             run [NPG];

  always #10 clk = ~clk;

  pg_sequencer #(.NUM_PG(NPG), .PGD_CYCLES(PGD), .SYNC_STAGES(2)) u_pg_sequencer (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .gate_ok_i   (gate_ok),
    .drain_low_i (drain_low),
    .en_i        (en),
    .pg_drive_o  (pg)
  );

  function automatic logic levels_ok(input int k);
    for (int j = 0; j < k; j++) if (!m_s2[j]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic [NPG-1:0] expect_pg();
    logic [NPG-1:0] e;
    e[0] = gate_ok & drain_low;
    for (int k = 1; k < NPG; k++)
      e[k] = e[k-1] && levels_ok(k) && (run[k] >= PGD);
    return e;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0;
      m_s2 = '0;
      for (int k = 0; k < NPG; k++) run[k] = 0;
    end else begin
      logic [NPG-1:0] e;
      e = expect_pg();
      for (int k = 1; k < NPG; k++) begin
        if (gate_ok && drain_low && e[k-1] && levels_ok(k))
          run[k] = (run[k] >= PGD) ? PGD : run[k] + 1;
        else
          run[k] = 0;
      end
      m_s2 = m_s1;
      m_s1 = en;
    end
  end

  task automatic check_val(input string tag, input logic [NPG-1:0] want);
    n_checks++;
    if (pg !== want) begin
      n_fail++;
      $display("FAIL %s: pg_drive_o=%b expected %b at %0t", tag, pg, want, $time);
    end
  endtask

  task automatic check_now(input string tag);
    #1;
    check_val(tag, expect_pg());
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    @(negedge clk);
    #1;
    check_val(tag, expect_pg());
  endtask

  task automatic steps(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < NPG; k++) run[k] = 0;
    // R1: reset state
    steps(3, "R1 in reset");
    check_val("R1 reset value", 4'b0000);
    gate_ok = 1'b1; drain_low = 1'b1;
    check_now("R2 during reset");
    check_val("R1 upper bits released in reset", 4'b0001);
    gate_ok = 1'b0; drain_low = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    steps(3, "R1 after reset");

    // Bring-up with all levels open: spacing and bit order.
    gate_ok = 1'b1; drain_low = 1'b1;
    check_now("R2 immediate first output");
    check_val("R10 bit0 is first output", 4'b0001);
    steps(PGD - 1, "R3 spacing");
    check_val("R3 bit1 not before delay", 4'b0001);
    step("R3 spacing");
    check_val("R3 bit1 after exactly delay", 4'b0011);
    steps(PGD, "R3 spacing");
    check_val("R3 bit2 after delay", 4'b0111);
    steps(PGD, "R3 spacing");
    check_val("R10 all pulled low", 4'b1111);

    // R4 / R9: drop level A, effect after two edges.
    en = 3'b110;
    step("R9 sync latency");
    check_val("R9 no effect after one edge", 4'b1111);
    step("R4 level A");
    check_val("R4 level A releases 3:1", 4'b0001);
    // R8: restore A, full delay again.
    en = 3'b111;
    steps(2 + PGD - 1, "R8 reenable");
    check_val("R8 still waiting", 4'b0001);
    step("R8 reenable");
    check_val("R8 full delay after reenable", 4'b0011);
    steps(2 * PGD + 2, "R3 regrow");

    // R5: level B.
    en = 3'b101;
    steps(2, "R5 level B");
    check_val("R5 level B releases 3:2", 4'b0011);
    en = 3'b111;
    steps(2 * PGD + 2, "R8 regrow");
    // R6: level C.
    en = 3'b011;
    steps(2, "R6 level C");
    check_val("R6 level C releases 3", 4'b0111);
    en = 3'b111;
    steps(PGD + 2, "R8 regrow");
    check_val("R8 regrown", 4'b1111);

    // R7: qualifier drop mid-sequence and restart.
    drain_low = 1'b0;
    check_now("R7 drain drop");
    check_val("R7 release all at once", 4'b0000);
    step("R7 cleared");
    drain_low = 1'b1;
    check_now("R7 restart");
    steps(PGD - 1, "R7 restart");
    check_val("R7 counters cleared", 4'b0001);
    step("R7 restart");
    steps(PGD - 2, "R7 partial");
    gate_ok = 1'b0;
    check_now("R7 gate drop");
    check_val("R7 gate drop releases all", 4'b0000);
    gate_ok = 1'b1;

    // Random phase: collisions of delay expiry with drops.
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(39) == 0) gate_ok = ~gate_ok;
      else if (!gate_ok && $urandom_range(3) == 0) gate_ok = 1'b1;
      if ($urandom_range(49) == 0) drain_low = ~drain_low;
      else if (!drain_low && $urandom_range(3) == 0) drain_low = 1'b1;
      for (int b = 0; b < NPG - 1; b++) begin
        if ($urandom_range(24) == 0) en[b] = ~en[b];
        else if (!en[b] && $urandom_range(9) == 0) en[b] = 1'b1;
      end
      check_now("R2 R4 R5 R6 random");
      step("R3 R7 R8 R9 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule